// File: doc/BRIEF.md
# Post-Update Load/Store Unit

This unit carries out a single load or store whose base register is advanced after the access. The unit uses the old base value, unchanged, as the memory address. It then writes the base register back with that value plus an offset. The offset is one of two things, selected by the decoded form:

- a 16-bit immediate, sign-extended;
- the contents of an index register.

For doubleword accesses in the immediate form, the two lowest immediate bits are treated as zero. The unit also accepts already-decoded operation controls and 64-bit operand values. It talks to memory over a synchronous request/response port and returns results on two register write ports, one for the data target and one for the base.

Operations enter on a valid/ready handshake and are accepted only while the unit is idle. The memory request is held, unchanged, until memory raises ready. The response is taken only after the request has been accepted, and it arrives right-aligned in a 64-bit word.

Loads whose base index is zero, or whose base index equals the target index, are illegal. For these the unit does not touch memory, writes no register, and reports the illegal form on its completion cycle. Every operation ends with a single-cycle `done` pulse. Address arithmetic wraps modulo 2^64.

Top module: `postinc_lsu`

## Requirements
- R1: `op_ready` is high only while idle. An operation is captured on the edge where `op_valid` and `op_ready` are both high, and operand inputs are ignored from then until `done`.
- R2: One cycle after a legal operation is accepted, `mem_req_valid` rises with `mem_req_addr` equal to the captured base value. `mem_req_size` equals `op_size` (0 byte, 1 halfword, 2 word, 3 doubleword) and `mem_req_we` equals `op_store`.
- R3: For stores, `mem_req_wdata` holds the low 1, 2, 4 or 8 bytes of the store operand, with every higher bit cleared.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all its fields stay unchanged. `mem_rsp_ready` rises only after the request has been accepted.
- R5: In the immediate form (`op_indexed`=0), the base writeback equals base plus `op_imm` sign-extended from bit 15.
- R6: In the immediate form with doubleword size, bits 1:0 of `op_imm` are ignored (taken as zero) before sign extension.
- R7: In the indexed form (`op_indexed`=1), the base writeback equals base plus `idx_val`.
- R8: Byte, halfword and word loads with `op_signed`=0 return the low 8, 16 or 32 response bits zero-extended. Response bits above the access size are ignored.
- R9: Halfword and word loads with `op_signed`=1 sign-extend to 64 bits. `op_signed` has no effect on byte and doubleword loads, and a doubleword load returns the response word unchanged.
- R10: A load with `ra_idx`=0, or with `ra_idx`=`rt_idx`, issues no memory request. One cycle after acceptance it pulses `done` and `invalid_form`, with both write enables low. Stores are never illegal.
- R11: A legal load completes one cycle after the response is taken. In that cycle `done`, `wr_t_en` and `wr_a_en` are high together, with indices `rt_idx` and `ra_idx`. A store raises only `wr_a_en`.
- R12: `done` is a single-cycle pulse, and `op_ready` returns high in the following cycle.
- R13: The base writeback wraps modulo 2^64 without any overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation may be accepted |
| op_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| op_store | input | 1 | 1 store, 0 load |
| op_signed | input | 1 | Sign-extend halfword/word loads |
| op_indexed | input | 1 | Offset from index register instead of immediate |
| op_imm | input | 16 | Immediate offset field |
| rt_idx | input | 5 | Load target / store source register index |
| ra_idx | input | 5 | Base register index |
| ra_val | input | 64 | Base register contents |
| idx_val | input | 64 | Index register contents |
| rs_val | input | 64 | Store operand contents |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Request address (old base) |
| mem_req_size | output | 2 | Request size code |
| mem_req_we | output | 1 | Write request |
| mem_req_wdata | output | 64 | Right-aligned store data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_ready | output | 1 | Unit accepts response |
| mem_rsp_data | input | 64 | Right-aligned read data |
| wr_t_en | output | 1 | Target register write enable |
| wr_t_idx | output | 5 | Target register index |
| wr_t_data | output | 64 | Target register data |
| wr_a_en | output | 1 | Base register write enable |
| wr_a_idx | output | 5 | Base register index |
| wr_a_data | output | 64 | Updated base value |
| done | output | 1 | Operation complete pulse |
| invalid_form | output | 1 | Completed operation was an illegal form |

## Verification
Each result has a fixed latency:

- The memory request appears one cycle after acceptance.
- It then holds through any number of stall cycles.
- The writebacks and `done` follow one cycle after the response handshake.
- An illegal load pulses `done` one cycle after acceptance, without any request.

The bench drives inputs and samples outputs only on falling clock edges, so every check falls in the single cycle where its result is due. The bench also replaces the operand inputs with unrelated values straight after acceptance. This shows that every result comes from the captured operation.

// File: rtl/postinc_pkg.sv
package postinc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WB     = 2'd2
  } state_e;

  typedef struct packed {
    size_e size;
    logic  store;
    logic  sext;
    logic  indexed;
  } ctl_t;

endpackage

// File: rtl/postinc_offset.sv
module postinc_offset
  import postinc_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  ctl_t             ctl,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  index,
  output logic [XLEN-1:0]  next_base
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [IMM_W-1:0] imm_eff;
  logic [XLEN-1:0]  imm_ext;
  logic [XLEN-1:0]  offset;

  // doubleword immediates carry a word-aligned displacement
  always_comb begin
    imm_eff = imm;
    if (ctl.size == SZ_DWORD) imm_eff[1:0] = 2'b00;
  end

  assign imm_ext   = {{EXT_W{imm_eff[IMM_W-1]}}, imm_eff};
  assign offset    = ctl.indexed ? index : imm_ext;
  assign next_base = base + offset;

endmodule

// File: rtl/postinc_datafmt.sv
module postinc_datafmt
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  size_e           size,
  input  logic            sext,
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);

  localparam int B_W = 8;
  localparam int H_W = 16;
  localparam int W_W = 32;

  logic h_fill;
  logic w_fill;

  assign h_fill = sext & din[H_W-1];
  assign w_fill = sext & din[W_W-1];

  always_comb begin
    unique case (size)
      SZ_BYTE:  dout = {{(XLEN-B_W){1'b0}}, din[B_W-1:0]};
      SZ_HALF:  dout = {{(XLEN-H_W){h_fill}}, din[H_W-1:0]};
      SZ_WORD:  dout = {{(XLEN-W_W){w_fill}}, din[W_W-1:0]};
      default:  dout = din;
    endcase
  end

endmodule

// File: rtl/postinc_seq.sv
module postinc_seq
  import postinc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_fire,
  input  logic op_bad,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic idle,
  output logic req_valid,
  output logic rsp_ready,
  output logic rsp_take,
  output logic wb,
  output logic bad
);

  state_e state_q, state_d;
  logic   sent_q, sent_d;
  logic   bad_q, bad_d;

  always_comb begin
    state_d = state_q;
    sent_d  = sent_q;
    bad_d   = bad_q;
    unique case (state_q)
      ST_IDLE: begin
        if (op_fire) begin
          bad_d   = op_bad;
          sent_d  = 1'b0;
          state_d = op_bad ? ST_WB : ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (!sent_q && req_ready) sent_d = 1'b1;
        if (sent_q && rsp_valid) state_d = ST_WB;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
      bad_q   <= bad_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_ACCESS) && !sent_q;
  assign rsp_ready = (state_q == ST_ACCESS) && sent_q;
  assign rsp_take  = rsp_ready && rsp_valid;
  assign wb        = (state_q == ST_WB);
  assign bad       = bad_q;

endmodule

// File: rtl/postinc_lsu.sv
module postinc_lsu
  import postinc_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_size,
  input  logic             op_store,
  input  logic             op_signed,
  input  logic             op_indexed,
  input  logic [IMM_W-1:0] op_imm,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  idx_val,
  input  logic [XLEN-1:0]  rs_val,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [1:0]       mem_req_size,
  output logic             mem_req_we,
  output logic [XLEN-1:0]  mem_req_wdata,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [XLEN-1:0]  mem_rsp_data,
  output logic             wr_t_en,
  output logic [IDX_W-1:0] wr_t_idx,
  output logic [XLEN-1:0]  wr_t_data,
  output logic             wr_a_en,
  output logic [IDX_W-1:0] wr_a_idx,
  output logic [XLEN-1:0]  wr_a_data,
  output logic             done,
  output logic             invalid_form
);

  ctl_t             ctl_in, ctl_q;
  logic [IMM_W-1:0] imm_q;
  logic [IDX_W-1:0] rt_q, ra_q;
  logic [XLEN-1:0]  base_q, index_q, src_q, rsp_q;
  logic             op_fire, op_bad;
  logic             rsp_take, wb, bad;

  assign ctl_in  = '{size: size_e'(op_size), store: op_store,
                     sext: op_signed, indexed: op_indexed};
  assign op_fire = op_valid && op_ready;
  assign op_bad  = !op_store && ((ra_idx == '0) || (ra_idx == rt_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      imm_q   <= '0;
      rt_q    <= '0;
      ra_q    <= '0;
      base_q  <= '0;
      index_q <= '0;
      src_q   <= '0;
    end else if (op_fire) begin
      ctl_q   <= ctl_in;
      imm_q   <= op_imm;
      rt_q    <= rt_idx;
      ra_q    <= ra_idx;
      base_q  <= ra_val;
      index_q <= idx_val;
      src_q   <= rs_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_q <= '0;
    else if (rsp_take) rsp_q <= mem_rsp_data;
  end

  postinc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_fire   (op_fire),
    .op_bad    (op_bad),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .idle      (op_ready),
    .req_valid (mem_req_valid),
    .rsp_ready (mem_rsp_ready),
    .rsp_take  (rsp_take),
    .wb        (wb),
    .bad       (bad)
  );

  postinc_offset #(.XLEN(XLEN), .IMM_W(IMM_W)) u_offset (
    .ctl       (ctl_q),
    .imm       (imm_q),
    .base      (base_q),
    .index     (index_q),
    .next_base (wr_a_data)
  );

  postinc_datafmt #(.XLEN(XLEN)) u_loadfmt (
    .size (ctl_q.size),
    .sext (ctl_q.sext),
    .din  (rsp_q),
    .dout (wr_t_data)
  );

  postinc_datafmt #(.XLEN(XLEN)) u_storefmt (
    .size (ctl_q.size),
    .sext (1'b0),
    .din  (src_q),
    .dout (mem_req_wdata)
  );

  assign mem_req_addr = base_q;
  assign mem_req_size = ctl_q.size;
  assign mem_req_we   = ctl_q.store;

  assign done         = wb;
  assign invalid_form = wb && bad;
  assign wr_a_en      = wb && !bad;
  assign wr_t_en      = wb && !bad && !ctl_q.store;
  assign wr_a_idx     = ra_q;
  assign wr_t_idx     = rt_q;

endmodule

// File: rtl/postinc_lsu_chk.sv
module postinc_lsu_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             op_store,
  input logic [IDX_W-1:0] rt_idx,
  input logic [IDX_W-1:0] ra_idx,
  input logic [XLEN-1:0]  ra_val,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic [1:0]       mem_req_size,
  input logic             mem_req_we,
  input logic [XLEN-1:0]  mem_req_wdata,
  input logic             mem_rsp_ready,
  input logic             wr_t_en,
  input logic             wr_a_en,
  input logic             done,
  input logic             invalid_form
);

  logic accept, accept_bad;
  assign accept     = op_valid && op_ready;
  assign accept_bad = accept && !op_store && ((ra_idx == '0) || (ra_idx == rt_idx));

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !op_ready);

  // R2
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accept_bad) |=> (mem_req_valid && mem_req_addr == $past(ra_val)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_size) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R4
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  // R10
  bad_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (!mem_req_valid && invalid_form && done));

  // R10
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_form |-> (!wr_t_en && !wr_a_en));

  // R11
  paired_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t_en |-> (wr_a_en && done));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && op_ready));

endmodule

bind postinc_lsu postinc_lsu_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_store      (op_store),
  .rt_idx        (rt_idx),
  .ra_idx        (ra_idx),
  .ra_val        (ra_val),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_we    (mem_req_we),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_ready (mem_rsp_ready),
  .wr_t_en       (wr_t_en),
  .wr_a_en       (wr_a_en),
  .done          (done),
  .invalid_form  (invalid_form)
);

// File: tb/postinc_lsu_test.sv
module postinc_lsu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_store = 1'b0;
  logic        op_signed = 1'b0;
  logic        op_indexed = 1'b0;
  logic [15:0] op_imm = '0;
  logic [4:0]  rt_idx = '0;
  logic [4:0]  ra_idx = '0;
  logic [63:0] ra_val = '0;
  logic [63:0] idx_val = '0;
  logic [63:0] rs_val = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_req_we;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        wr_t_en;
  logic [4:0]  wr_t_idx;
  logic [63:0] wr_t_data;
  logic        wr_a_en;
  logic [4:0]  wr_a_idx;
  logic [63:0] wr_a_data;
  logic        done;
  logic        invalid_form;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  postinc_lsu uut (.*);

  typedef struct packed {
    logic [1:0]  sz;
    logic        st;
    logic        sg;
    logic        ix;
    logic [1:0]  stall;
    logic [15:0] imm;
    logic [4:0]  rt;
    logic [4:0]  ra;
    logic [63:0] base;
    logic [63:0] index;
    logic [63:0] src;
    logic [63:0] rsp;
    logic [63:0] exp_d;
    logic [63:0] exp_a;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R8 R9 R5: signed byte load is zero-extended, positive immediate
    '{2'd0,1'b0,1'b1,1'b0,2'd0,16'h0010,5'd3,5'd4,64'h1000,64'h0,64'h0,
      64'hFFFF_FFFF_FFFF_FF85,64'h85,64'h1010},
    // R9 R5 R4: signed half load, negative immediate, stalled request
    '{2'd1,1'b0,1'b1,1'b0,2'd2,16'hFFFE,5'd5,5'd6,64'h2000,64'h0,64'h0,
      64'h1234_5678_9ABC_8001,64'hFFFF_FFFF_FFFF_8001,64'h1FFE},
    // R8 R7: unsigned half, indexed
    '{2'd1,1'b0,1'b0,1'b1,2'd0,16'h0000,5'd7,5'd8,64'h3000,64'h100,64'h0,
      64'hAAAA_AAAA_AAAA_F00D,64'hF00D,64'h3100},
    // R9 R7: signed word, negative index
    '{2'd2,1'b0,1'b1,1'b1,2'd1,16'h0000,5'd9,5'd10,64'h10,64'hFFFF_FFFF_FFFF_FFF0,64'h0,
      64'h0000_0000_8765_4321,64'hFFFF_FFFF_8765_4321,64'h0},
    // R8 R5: unsigned word, largest positive immediate
    '{2'd2,1'b0,1'b0,1'b0,2'd0,16'h7FFF,5'd11,5'd12,64'h4000,64'h0,64'h0,
      64'hDEAD_BEEF_C0DE_CAFE,64'hC0DE_CAFE,64'hBFFF},
    // R6 R9: doubleword immediate, low imm bits dropped
    '{2'd3,1'b0,1'b0,1'b0,2'd0,16'hFFF7,5'd13,5'd14,64'h5000,64'h0,64'h0,
      64'h0123_4567_89AB_CDEF,64'h0123_4567_89AB_CDEF,64'h4FF4},
    // R9 R7: doubleword with signed flag, indexed
    '{2'd3,1'b0,1'b1,1'b1,2'd0,16'h0003,5'd15,5'd16,64'h6000,64'h8,64'h0,
      64'h8000_0000_0000_0001,64'h8000_0000_0000_0001,64'h6008},
    // R3 R5: byte store
    '{2'd0,1'b1,1'b0,1'b0,2'd0,16'h0001,5'd17,5'd18,64'h7000,64'h0,64'h1122_3344_5566_7788,
      64'h0,64'h88,64'h7001},
    // R3 R7: half store, indexed
    '{2'd1,1'b1,1'b0,1'b1,2'd0,16'h0000,5'd19,5'd20,64'h8000,64'h2,64'h1122_3344_5566_7788,
      64'h0,64'h7788,64'h8002},
    // R3 R5: word store, most negative immediate
    '{2'd2,1'b1,1'b1,1'b0,2'd0,16'h8000,5'd21,5'd22,64'h10000,64'h0,64'h1122_3344_5566_7788,
      64'h0,64'h5566_7788,64'h8000},
    // R3 R6 R4: doubleword store with stall
    '{2'd3,1'b1,1'b0,1'b0,2'd1,16'h0006,5'd23,5'd24,64'h9000,64'h0,64'h1122_3344_5566_7788,
      64'h0,64'h1122_3344_5566_7788,64'h9004},
    // R13: base wraps past the top of the address space
    '{2'd0,1'b0,1'b0,1'b1,2'd0,16'h0000,5'd25,5'd26,64'hFFFF_FFFF_FFFF_FFFF,64'h2,64'h0,
      64'h7F,64'h7F,64'h1},
    // R10: store with base index 0 and equal to source is legal
    '{2'd0,1'b1,1'b0,1'b0,2'd0,16'h0004,5'd0,5'd0,64'h20,64'h0,64'h1122_3344_5566_7788,
      64'h0,64'h88,64'h24}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input vec_t v);
    op_valid   = 1'b1;
    op_size    = v.sz;
    op_store   = v.st;
    op_signed  = v.sg;
    op_indexed = v.ix;
    op_imm     = v.imm;
    rt_idx     = v.rt;
    ra_idx     = v.ra;
    ra_val     = v.base;
    idx_val    = v.index;
    rs_val     = v.src;
  endtask

  task automatic scramble();
    op_valid   = 1'b0;
    op_size    = 2'd3;
    op_imm     = 16'h5A5A;
    ra_val     = 64'hDEAD_0000_DEAD_0000;
    idx_val    = 64'h0BAD_0BAD_0BAD_0BAD;
    rs_val     = 64'hCAFE_CAFE_CAFE_CAFE;
    rt_idx     = 5'd30;
    ra_idx     = 5'd31;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    string tag;
    tag = $sformatf("vec%0d", n);
    chk({"R1 ready before ", tag}, 64'(op_ready), 64'h1);
    present(v);
    @(negedge clk);
    scramble();
    chk({"R1 busy ", tag}, 64'(op_ready), 64'h0);
    chk({"R2 req valid ", tag}, 64'(mem_req_valid), 64'h1);
    chk({"R2 addr ", tag}, mem_req_addr, v.base);
    chk({"R2 size ", tag}, 64'(mem_req_size), 64'(v.sz));
    chk({"R2 we ", tag}, 64'(mem_req_we), 64'(v.st));
    if (v.st) chk({"R3 wdata ", tag}, mem_req_wdata, v.exp_d);
    for (int s = 0; s < int'(v.stall); s++) begin
      @(negedge clk);
      chk({"R4 held ", tag}, 64'(mem_req_valid), 64'h1);
      chk({"R4 addr held ", tag}, mem_req_addr, v.base);
      chk({"R4 no rsp ready ", tag}, 64'(mem_rsp_ready), 64'h0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk({"R4 req dropped ", tag}, 64'(mem_req_valid), 64'h0);
    chk({"R4 rsp ready ", tag}, 64'(mem_rsp_ready), 64'h1);
    chk({"R11 not done yet ", tag}, 64'(done), 64'h0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = v.rsp;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 64'h0;
    chk({"R11 done ", tag}, 64'(done), 64'h1);
    chk({"R10 not invalid ", tag}, 64'(invalid_form), 64'h0);
    chk({"R11 base wen ", tag}, 64'(wr_a_en), 64'h1);
    chk({"R11 base idx ", tag}, 64'(wr_a_idx), 64'(v.ra));
    chk({"R5 R7 R13 base value ", tag}, wr_a_data, v.exp_a);
    chk({"R11 target wen ", tag}, 64'(wr_t_en), 64'(!v.st));
    if (!v.st) begin
      chk({"R11 target idx ", tag}, 64'(wr_t_idx), 64'(v.rt));
      chk({"R8 R9 load data ", tag}, wr_t_data, v.exp_d);
    end
    @(negedge clk);
    chk({"R12 done pulse ", tag}, 64'(done), 64'h0);
    chk({"R12 ready again ", tag}, 64'(op_ready), 64'h1);
  endtask

  task automatic run_bad(input logic [4:0] rt, input logic [4:0] ra, input string tag);
    vec_t v;
    v = '0;
    v.sz = 2'd2;
    v.rt = rt;
    v.ra = ra;
    v.base = 64'h4444;
    present(v);
    @(negedge clk);
    scramble();
    chk({"R10 no request ", tag}, 64'(mem_req_valid), 64'h0);
    chk({"R10 done ", tag}, 64'(done), 64'h1);
    chk({"R10 invalid ", tag}, 64'(invalid_form), 64'h1);
    chk({"R10 no target write ", tag}, 64'(wr_t_en), 64'h0);
    chk({"R10 no base write ", tag}, 64'(wr_a_en), 64'h0);
    @(negedge clk);
    chk({"R12 done pulse ", tag}, 64'(done), 64'h0);
    chk({"R12 ready ", tag}, 64'(op_ready), 64'h1);
    chk({"R10 still no request ", tag}, 64'(mem_req_valid), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(op_ready), 64'h1);
    chk("R12 reset done", 64'(done), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 64'(op_ready), 64'h1);
    chk("R2 no request after reset", 64'(mem_req_valid), 64'h0);
    chk("R11 no writes after reset", 64'({wr_t_en, wr_a_en}), 64'h0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    run_bad(5'd4, 5'd0, "base index zero");
    run_bad(5'd7, 5'd7, "base equals target");
    run_vec(VECS[2], 99);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule